// File: doc/BRIEF.md
# UART Bit-Rate Clock Generator

This block produces all bit timing for a serial port that can run either asynchronously or with a shared shift clock. The system clock passes through two counting stages. The first is a prescaler whose divide factor is programmed in half-unit steps from 1.0 to 16.0. The second is a divisor counter that divides the prescaler ticks by N. In asynchronous mode an oversampling counter follows. It emits a mid-bit sample strobe and a bit-boundary strobe, and the bit period is O × N × P system clocks.

In synchronous mode the oversampling stage is idle. The block then works in one of two ways. It can toggle a shift clock from the divisor ticks and drive it onto a bidirectional clock pin. Or it can release the pin, synchronize the clock that arrives on it, and emit one-cycle rising and falling edge strobes. Synchronous operation exists only on instances built with the capability parameter set. On any other instance a synchronous request is ignored.

The block takes its divide fields, mode bits and an enable from the surrounding register logic. A field-write strobe restarts all counting. The shifter and the framing logic sit outside this block.

Top module: `ubg_baud_gen`

## Requirements
- R1: After reset, and whenever `en` is low, no strobe is issued, `sclk_out` is 0 and `sclk_oe` is 0.
- R2: `psc_code` selects P = 1 + psc_code/2 (codes 0..30). With an odd code, successive prescaler periods alternate between floor(P) and ceil(P) system clocks, starting with floor(P). Tick t therefore falls t·floor(P) + floor(t/2) cycles after counting starts, where counting starts in cycle 1.
- R3: The divisor stage divides by N = `div_val` + 1, so one divisor tick is issued for every N prescaler ticks.
- R4: `ovs_sel` selects O = `ovs_sel` + 1 for values 6..15. Values below 6 act as 6, giving O = 7. `bit_stb` is issued on the O-th divisor tick of each bit.
- R5: `smp_stb` is issued on divisor tick floor(O/2) of each bit. It never coincides with `bit_stb`.
- R6: With `SYNC_OK` = 0, `sync_mode` has no effect: the async strobes keep the full-P timing of R2 to R4, and `sclk_oe` stays 0.
- R7: In synchronous mode with `ext_clk_sel` = 0, `sclk_oe` is 1 and `sclk_out` starts at 0. `sclk_out` toggles after every N·floor(P) system clocks. `sclk_rise` or `sclk_fall` is high in the last cycle before each toggle, and names the direction of that toggle.
- R8: In synchronous mode with `ext_clk_sel` = 1, `sclk_oe` is 0 and `sclk_in` passes through two synchronizer flops. A level change made before a clock edge gives a one-cycle `sclk_rise` or `sclk_fall` in the cycle that follows the second edge.
- R9: In synchronous mode `smp_stb` and `bit_stb` stay 0.
- R10: While `cfg_wr` is high, no strobe is issued and every counter returns to its start value. Timing restarts from cycle 1 in the first cycle after `cfg_wr` falls.
- R11: In synchronous mode the half step of P is dropped, so the prescaler divides by floor(P) on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable |
| cfg_wr | input | 1 | Field-write strobe; restarts counting |
| psc_code | input | PSC_W | Prescaler code, P = 1 + code/2 |
| div_val | input | DIV_W | Divisor value, N = div_val + 1 |
| ovs_sel | input | OVS_W | Oversampling select, O = ovs_sel + 1 |
| sync_mode | input | 1 | Request synchronous operation |
| ext_clk_sel | input | 1 | Synchronous clock source: 1 = pin, 0 = internal |
| sclk_in | input | 1 | Clock pin input level |
| sclk_out | output | 1 | Clock pin output level |
| sclk_oe | output | 1 | Clock pin output enable |
| smp_stb | output | 1 | Asynchronous mid-bit sample strobe |
| bit_stb | output | 1 | Asynchronous bit-boundary strobe |
| sclk_rise | output | 1 | Synchronous rising-edge strobe |
| sclk_fall | output | 1 | Synchronous falling-edge strobe |

## Verification
The assertions check properties that must hold on every cycle. The prescaler count stays below its current period, a divisor tick only occurs on a prescaler tick, and the sample and boundary strobes never collide. The internal shift clock changes level exactly after a divisor tick, and no strobe appears while the block is idle. What the assertions cannot show is the absolute cycle placement: the floor/ceil alternation, the N and O counts, the clamp of small oversampling selects, and the restart after a field write. The bench shows these by sweeping prescaler codes, divisors and oversampling selects, and by comparing each strobe's cycle against times it computes itself.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int unsigned OVS_MIN_LAST = 6;

  // whole part of the doubled prescaler factor (code + 2) / 2
  function automatic int unsigned psc_base(input int unsigned code);
    return (code + 2) / 2;
  endfunction

  // a half step exists when code + 2 is odd
  function automatic logic psc_half(input int unsigned code);
    return ((code + 2) % 2) == 1;
  endfunction

  // last oversample index (O - 1), small selects clamped
  function automatic int unsigned ovs_last(input int unsigned sel);
    return (sel < OVS_MIN_LAST) ? OVS_MIN_LAST : sel;
  endfunction

  // oversample index at which the sample strobe fires (floor(O/2) - 1)
  function automatic int unsigned ovs_mid(input int unsigned last);
    return ((last + 1) / 2) - 1;
  endfunction
endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             int_only,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  import ubg_pkg::*;
  localparam int CNT_W = PSC_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] len;
  logic             half;
  logic             phase;

  always_comb begin
    base = CNT_W'(psc_base(int'(code)));
    half = psc_half(int'(code)) && !int_only;
    len  = base + CNT_W'(half && phase);
    tick = active && (cnt == len - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!active) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase ^ half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < len));

  // R11
  psc_int_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && int_only && $past(active) && $past(int_only)) |-> !phase);
endmodule

// File: rtl/ubg_divider.sv
module ubg_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             psc_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = psc_tick && (cnt == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!active)        cnt <= '0;
    else if (psc_tick)       cnt <= (cnt == div_val) ? '0 : cnt + 1'b1;
  end

  // R3
  div_on_psc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> psc_tick);

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $stable(div_val)) |-> (cnt <= div_val));
endmodule

// File: rtl/ubg_oversampler.sv
module ubg_oversampler #(
  parameter int OVS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_tick,
  input  logic [OVS_W-1:0] ovs_sel,
  output logic             smp_stb,
  output logic             bit_stb
);
  import ubg_pkg::*;

  logic [OVS_W-1:0] cnt;
  logic [OVS_W-1:0] last;
  logic [OVS_W-1:0] mid;
  logic             adv;

  always_comb begin
    last    = OVS_W'(ovs_last(int'(ovs_sel)));
    mid     = OVS_W'(ovs_mid(int'(last)));
    adv     = run && div_tick;
    bit_stb = adv && (cnt == last);
    smp_stb = adv && (cnt == mid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (adv)      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  // R5
  smp_bit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_stb && bit_stb));

  // R4
  ovs_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb || bit_stb) |-> (run && div_tick));
endmodule

// File: rtl/ubg_sclk.sv
module ubg_sclk (
  input  logic clk,
  input  logic rst_n,
  input  logic int_run,
  input  logic ext_run,
  input  logic div_tick,
  input  logic pin_in,
  output logic sclk_q,
  output logic rise,
  output logic fall
);
  logic s1, s2, s2_d;
  logic int_rise, int_fall, ext_rise, ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s2_d <= 1'b0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      s2_d <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sclk_q <= 1'b0;
    else if (!int_run)   sclk_q <= 1'b0;
    else if (div_tick)   sclk_q <= ~sclk_q;
  end

  always_comb begin
    int_rise = int_run && div_tick && !sclk_q;
    int_fall = int_run && div_tick && sclk_q;
    ext_rise = ext_run && s2 && !s2_d;
    ext_fall = ext_run && !s2 && s2_d;
    rise     = int_rise || ext_rise;
    fall     = int_fall || ext_fall;
  end

  // R7
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_run && div_tick) |=> (!int_run || sclk_q != $past(sclk_q)));

  // R8
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/ubg_baud_gen.sv
module ubg_baud_gen #(
  parameter int PSC_W   = 5,
  parameter int DIV_W   = 12,
  parameter int OVS_W   = 4,
  parameter bit SYNC_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_wr,
  input  logic [PSC_W-1:0] psc_code,
  input  logic [DIV_W-1:0] div_val,
  input  logic [OVS_W-1:0] ovs_sel,
  input  logic             sync_mode,
  input  logic             ext_clk_sel,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             smp_stb,
  output logic             bit_stb,
  output logic             sclk_rise,
  output logic             sclk_fall
);
  logic active;
  logic sync_eff;
  logic int_run;
  logic ext_run;
  logic async_run;
  logic psc_tick;
  logic div_tick;

  assign active    = en && !cfg_wr;
  assign sync_eff  = SYNC_OK && sync_mode;
  assign int_run   = active && sync_eff && !ext_clk_sel;
  assign ext_run   = active && sync_eff && ext_clk_sel;
  assign async_run = active && !sync_eff;
  assign sclk_oe   = en && sync_eff && !ext_clk_sel;

  ubg_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .active(active), .int_only(sync_eff),
    .code(psc_code), .tick(psc_tick)
  );

  ubg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .active(active), .psc_tick(psc_tick),
    .div_val(div_val), .tick(div_tick)
  );

  ubg_oversampler #(.OVS_W(OVS_W)) u_ovs (
    .clk(clk), .rst_n(rst_n), .run(async_run), .div_tick(div_tick),
    .ovs_sel(ovs_sel), .smp_stb(smp_stb), .bit_stb(bit_stb)
  );

  ubg_sclk u_sclk (
    .clk(clk), .rst_n(rst_n), .int_run(int_run), .ext_run(ext_run),
    .div_tick(div_tick), .pin_in(sclk_in), .sclk_q(sclk_out),
    .rise(sclk_rise), .fall(sclk_fall)
  );

  // R1 R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(smp_stb || bit_stb || sclk_rise || sclk_fall));

  // R9
  sync_no_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && SYNC_OK) |-> !(smp_stb || bit_stb));

  // R6 R8
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (sync_mode && !ext_clk_sel && en));

  // R1
  out_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!en || !sclk_out) );
endmodule

// File: tb/ubg_baud_gen_tb.sv
`timescale 1ns/1ps
module ubg_baud_gen_tb;
  localparam int PSC_W = 5;
  localparam int DIV_W = 12;
  localparam int OVS_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [PSC_W-1:0] psc_code = '0;
  logic [DIV_W-1:0] div_val = '0;
  logic [OVS_W-1:0] ovs_sel = 4'd6;
  logic sync_mode = 1'b0;
  logic ext_clk_sel = 1'b0;
  logic sclk_in = 1'b0;

  logic sclk_out, sclk_oe, smp_stb, bit_stb, sclk_rise, sclk_fall;
  logic n_sclk_out, n_sclk_oe, n_smp, n_bit, n_rise, n_fall;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ubg_baud_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .OVS_W(OVS_W), .SYNC_OK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .psc_code(psc_code),
    .div_val(div_val), .ovs_sel(ovs_sel), .sync_mode(sync_mode),
    .ext_clk_sel(ext_clk_sel), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .smp_stb(smp_stb), .bit_stb(bit_stb),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  ubg_baud_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .OVS_W(OVS_W), .SYNC_OK(1'b0)) u_dut_ns (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .psc_code(psc_code),
    .div_val(div_val), .ovs_sel(ovs_sel), .sync_mode(sync_mode),
    .ext_clk_sel(ext_clk_sel), .sclk_in(sclk_in), .sclk_out(n_sclk_out),
    .sclk_oe(n_sclk_oe), .smp_stb(n_smp), .bit_stb(n_bit),
    .sclk_rise(n_rise), .sclk_fall(n_fall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle of prescaler tick t, counted from 1
  function automatic int tt(input int t, input int fl, input bit half);
    return t * fl + (half ? t / 2 : 0);
  endfunction

  // active just became true at this negedge; trace two bits
  task automatic trace_async(input bit use_ns, input int code, input int dv,
                             input int osel, input string req);
    int fl = (code + 2) / 2;
    bit half = ((code + 2) % 2) == 1;
    int n = dv + 1;
    int o = (osel < 6) ? 7 : osel + 1;
    int lim = tt(2 * o * n, fl, half);
    int bad_b = 0, bad_s = 0, fb = 0, fs = 0;
    for (int c = 1; c <= lim; c++) begin
      bit eb, es, ob, os;
      #1;
      eb = (c == tt(o * n, fl, half)) || (c == lim);
      es = (c == tt((o / 2) * n, fl, half)) || (c == tt((o + o / 2) * n, fl, half));
      ob = use_ns ? n_bit : bit_stb;
      os = use_ns ? n_smp : smp_stb;
      if (ob != eb && bad_b == 0) fb = c;
      if (os != es && bad_s == 0) fs = c;
      if (ob != eb) bad_b++;
      if (os != es) bad_s++;
      @(negedge clk);
    end
    chk(bad_b == 0, {req, " bit_stb timing"}, fb, 0);
    chk(bad_s == 0, {req, " smp_stb timing"}, fs, 0);
  endtask

  task automatic run_async(input int code, input int dv, input int osel, input string req);
    @(negedge clk);
    psc_code = PSC_W'(code); div_val = DIV_W'(dv); ovs_sel = OVS_W'(osel);
    sync_mode = 1'b0;
    @(negedge clk);
    en = 1'b1;
    trace_async(1'b0, code, dv, osel, req);
    en = 1'b0;
    @(negedge clk);
  endtask

  // R7 R11: internal shift clock
  task automatic run_sync_int(input int code, input int dv);
    int per = ((code + 2) / 2) * (dv + 1);
    int bad = 0, first = 0;
    @(negedge clk);
    psc_code = PSC_W'(code); div_val = DIV_W'(dv);
    sync_mode = 1'b1; ext_clk_sel = 1'b0;
    @(negedge clk);
    en = 1'b1;
    for (int c = 1; c <= 4 * per; c++) begin
      bit lvl, er, ef;
      #1;
      lvl = (((c - 1) / per) % 2) == 1;
      er = (c % per == 0) && (((c / per) % 2) == 1);
      ef = (c % per == 0) && (((c / per) % 2) == 0);
      if ((sclk_out != lvl || sclk_rise != er || sclk_fall != ef ||
           !sclk_oe || smp_stb || bit_stb) && bad == 0) first = c;
      if (sclk_out != lvl || sclk_rise != er || sclk_fall != ef ||
          !sclk_oe || smp_stb || bit_stb) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7/R11/R9 internal shift clock", first, 0);
    en = 1'b0;
    sync_mode = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state
    chk(!smp_stb && !bit_stb && !sclk_rise && !sclk_fall, "R1 idle strobes", 1, 0);
    chk(!sclk_out && !sclk_oe, "R1 idle pin", int'({sclk_out, sclk_oe}), 0);

    // R2 R3 R4 R5: sweep
    for (int code = 0; code < 6; code++)
      for (int dv = 0; dv < 3; dv++) begin
        run_async(code, dv, 6, "R2 R3 R4 R5 O=7");
        run_async(code, dv, 15, "R2 R3 R4 R5 O=16");
      end
    run_async(3, 1, 9, "R4 R5 O=10");
    run_async(30, 0, 6, "R2 max code");
    // R4: clamp of small select
    run_async(1, 1, 2, "R4 clamp");

    // R10: field write mid-count restarts timing
    @(negedge clk);
    psc_code = 5'd1; div_val = 12'd1; ovs_sel = 4'd6; sync_mode = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (9) @(negedge clk);
    cfg_wr = 1'b1;
    #1;
    chk(!smp_stb && !bit_stb, "R10 quiet during write", int'({smp_stb, bit_stb}), 0);
    @(negedge clk);
    cfg_wr = 1'b0;
    trace_async(1'b0, 1, 1, 6, "R10 restart");
    en = 1'b0;
    @(negedge clk);

    // R7 R11 R9
    run_sync_int(1, 2);
    run_sync_int(2, 1);
    run_sync_int(5, 0);

    // R6: sync request ignored on non-capable instance
    @(negedge clk);
    psc_code = 5'd1; div_val = 12'd1; ovs_sel = 4'd6;
    sync_mode = 1'b1; ext_clk_sel = 1'b0;
    @(negedge clk);
    en = 1'b1;
    trace_async(1'b1, 1, 1, 6, "R6 non-capable");
    chk(!n_sclk_oe && !n_sclk_out, "R6 non-capable pin", int'({n_sclk_oe, n_sclk_out}), 0);
    en = 1'b0;
    @(negedge clk);

    // R8: external clock
    ext_clk_sel = 1'b1; sync_mode = 1'b1; sclk_in = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!sclk_oe, "R8 oe released", int'(sclk_oe), 0);
    chk(!sclk_rise && !sclk_fall, "R8 no edge on steady pin", int'({sclk_rise, sclk_fall}), 0);
    sclk_in = 1'b1;
    @(negedge clk); #1;
    chk(!sclk_rise, "R8 rise not after one edge", int'(sclk_rise), 0);
    @(negedge clk); #1;
    chk(sclk_rise && !sclk_fall, "R8 rise after second edge", int'(sclk_rise), 1);
    @(negedge clk); #1;
    chk(!sclk_rise, "R8 rise one cycle", int'(sclk_rise), 0);
    chk(!smp_stb && !bit_stb, "R9 no async strobes", int'({smp_stb, bit_stb}), 0);
    sclk_in = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk(sclk_fall && !sclk_rise, "R8 fall after second edge", int'(sclk_fall), 1);
    @(negedge clk); #1;
    chk(!sclk_fall, "R8 fall one cycle", int'(sclk_fall), 0);

    // R1: disable again
    en = 1'b0;
    @(negedge clk); #1;
    chk(!sclk_oe && !sclk_out && !sclk_rise && !sclk_fall, "R1 disabled",
        int'({sclk_oe, sclk_out}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule